// File: doc/BRIEF.md
# Window-Compare Status Flags for Two Watched Converter Channels

This block watches the stream of conversion results coming out of a converter and compares the results of two watched channels against an upper and a lower threshold for each channel. A result at or above the upper threshold, or below the lower threshold, sets a status flag. The flag stays set until software clears it. The four flags sit in the top nibble of an 8-bit read/write status register. The same register also holds a 3-bit prescaler field, kept as plain storage for the converter clock divider, and one bit that is always one.

While any flag is set, the block raises an out-of-range interrupt request. Software clears flags in either of two ways. It can write the register, where a zero in a flag position clears that flag. It can also pulse the software-reset request of the interrupt control logic, which forces every flag to zero in hardware. The reset input is asynchronous and active low. It is expected to be released synchronously to `clk` by logic outside the block.

Top module: `window_flag_monitor`

## Requirements
- R1: After reset the register reads 0x0F. All four flags are zero, bit 3 is one and the prescaler field is 3'b111.
- R2: Register bit layout is fixed. Bit 7 is the channel-7 upper flag and bit 6 the channel-6 upper flag. Bit 5 is the channel-7 lower flag and bit 4 the channel-6 lower flag. Bit 3 is a constant and bits 2:0 are the prescaler field.
- R3: A result strobe for a watched channel whose data is greater than or equal to that channel's upper threshold sets the channel's upper flag. The flag reads back one cycle after the strobe.
- R4: A result strobe for a watched channel whose data is strictly below that channel's lower threshold sets the channel's lower flag. Data equal to the lower threshold does not set it.
- R5: Flags are sticky. A compare whose condition is false leaves every flag unchanged, and no compare ever clears a flag.
- R6: A register write clears each flag whose written bit is 0 and leaves each flag whose written bit is 1 unchanged. Bits 2:0 of the write are stored and read back as written.
- R7: A software-reset request pulse forces all four flags to zero on the next clock edge. It leaves the prescaler field unchanged.
- R8: Bit 3 always reads as 1, including after a write of 0 to it.
- R9: A result strobe whose channel index is neither 6 nor 7 has no effect on any flag, whatever its data.
- R10: A clear takes priority over a set in the same cycle. When a register write or a software-reset request coincides with a result strobe, the compare outcome of that strobe is discarded, and the flags take only the cleared value.
- R11: The interrupt request is high exactly when at least one of the four flags is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| res_valid | input | 1 | Conversion result strobe |
| res_chan | input | 4 | Channel index of the result |
| res_data | input | 8 | Converted value |
| thr_up_c6 | input | 8 | Upper threshold, channel 6 |
| thr_lo_c6 | input | 8 | Lower threshold, channel 6 |
| thr_up_c7 | input | 8 | Upper threshold, channel 7 |
| thr_lo_c7 | input | 8 | Lower threshold, channel 7 |
| reg_wr_en | input | 1 | Status register write strobe |
| reg_wr_data | input | 8 | Status register write value |
| sw_clr_req | input | 1 | Software-reset request pulse of the interrupt control logic |
| reg_rd_data | output | 8 | Status register read image |
| oor_irq | output | 1 | Out-of-range interrupt request |

## Verification
Every converted value from 0 to 255 is applied to each watched channel, one at a time, with a clear before each value. This is repeated under three threshold sets: a middle window, thresholds at zero and thresholds at full scale. The sweep shows the greater-or-equal rule from the strictly-less rule at the exact threshold value, and shows channel 6 apart from channel 7 by flag position. Runs without a clear between strobes show sticky behaviour apart from a compare that overwrites flags. Strobes for the other channel indices at both extremes of data confirm that those results are ignored. Writes and software-reset requests made alone and in the same cycle as a strobe show partial clears, full clears and the clear-over-set priority.

// File: rtl/wcmp_pkg.sv
package wcmp_pkg;
  localparam int REG_W   = 8;
  localparam int NFLAG   = 4;
  localparam int PR_W    = 3;
  localparam int NSLOT   = 2;
  localparam logic [PR_W-1:0] PR_RST = 3'b111;
  typedef logic [NFLAG-1:0] flag_vec_t;
endpackage

// File: rtl/wcmp_slot_cmp.sv
module wcmp_slot_cmp #(
  parameter int DATA_W = 8,
  parameter int CH_W   = 4,
  parameter int CH_ID  = 6
) (
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] thr_up,
  input  logic [DATA_W-1:0] thr_lo,
  output logic              hit_up,
  output logic              hit_lo
);
  localparam logic [CH_W-1:0] MY_CH = CH_W'(CH_ID);

  logic sel;

  always_comb begin
    sel    = res_valid && (res_chan == MY_CH);
    hit_up = sel && (res_data >= thr_up);
    hit_lo = sel && (res_data <  thr_lo);
  end
endmodule

// File: rtl/wcmp_flag_bank.sv
module wcmp_flag_bank
  import wcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  flag_vec_t set_vec,
  input  logic      wr_en,
  input  flag_vec_t wr_keep,
  input  logic      clr_all,
  output flag_vec_t flags
);
  flag_vec_t flags_q, flags_d;
  logic      flags_en;

  always_comb begin
    flags_en = clr_all || wr_en || (|set_vec);
    if (clr_all) begin
      flags_d = '0;
    end else if (wr_en) begin
      flags_d = flags_q & wr_keep;
    end else begin
      flags_d = flags_q | set_vec;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (flags_en) begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;
endmodule

// File: rtl/wcmp_prescale_store.sv
module wcmp_prescale_store
  import wcmp_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [PR_W-1:0] wr_val,
  output logic [PR_W-1:0] pr
);
  logic [PR_W-1:0] pr_q, pr_d;

  always_comb begin
    pr_d = wr_en ? wr_val : pr_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pr_q <= PR_RST;
    end else if (wr_en) begin
      pr_q <= pr_d;
    end
  end

  assign pr = pr_q;
endmodule

// File: rtl/window_flag_monitor.sv
module window_flag_monitor
  import wcmp_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int CH_W    = 4,
  parameter int CH_BASE = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [CH_W-1:0]   res_chan,
  input  logic [DATA_W-1:0] res_data,
  input  logic [DATA_W-1:0] thr_up_c6,
  input  logic [DATA_W-1:0] thr_lo_c6,
  input  logic [DATA_W-1:0] thr_up_c7,
  input  logic [DATA_W-1:0] thr_lo_c7,
  input  logic              reg_wr_en,
  input  logic [REG_W-1:0]  reg_wr_data,
  input  logic              sw_clr_req,
  output logic [REG_W-1:0]  reg_rd_data,
  output logic              oor_irq
);
  localparam int FLAG_LSB = REG_W - NFLAG;

  logic [NSLOT-1:0]  hit_up, hit_lo;
  logic [DATA_W-1:0] thr_up [NSLOT];
  logic [DATA_W-1:0] thr_lo [NSLOT];
  flag_vec_t         set_vec, flags;
  logic [PR_W-1:0]   pr;

  always_comb begin
    thr_up[0] = thr_up_c6;
    thr_lo[0] = thr_lo_c6;
    thr_up[1] = thr_up_c7;
    thr_lo[1] = thr_lo_c7;
  end

  for (genvar s = 0; s < NSLOT; s++) begin : g_slot
    wcmp_slot_cmp #(
      .DATA_W (DATA_W),
      .CH_W   (CH_W),
      .CH_ID  (CH_BASE + s)
    ) u_cmp (
      .res_valid (res_valid),
      .res_chan  (res_chan),
      .res_data  (res_data),
      .thr_up    (thr_up[s]),
      .thr_lo    (thr_lo[s]),
      .hit_up    (hit_up[s]),
      .hit_lo    (hit_lo[s])
    );
  end

  // Flag order, MSB first: upper c7, upper c6, lower c7, lower c6
  assign set_vec = {hit_up[1], hit_up[0], hit_lo[1], hit_lo[0]};

  wcmp_flag_bank u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vec (set_vec),
    .wr_en   (reg_wr_en),
    .wr_keep (reg_wr_data[REG_W-1:FLAG_LSB]),
    .clr_all (sw_clr_req),
    .flags   (flags)
  );

  wcmp_prescale_store u_pr (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (reg_wr_en),
    .wr_val (reg_wr_data[PR_W-1:0]),
    .pr     (pr)
  );

  assign reg_rd_data = {flags, 1'b1, pr};
  assign oor_irq     = |flags;
endmodule

// File: rtl/wcmp_checker.sv
module wcmp_checker #(
  parameter int DATA_W  = 8,
  parameter int CH_W    = 4,
  parameter int CH_BASE = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_chan,
  input logic [DATA_W-1:0] res_data,
  input logic [DATA_W-1:0] thr_up_c6,
  input logic [DATA_W-1:0] thr_lo_c6,
  input logic [DATA_W-1:0] thr_up_c7,
  input logic [DATA_W-1:0] thr_lo_c7,
  input logic              reg_wr_en,
  input logic [7:0]        reg_wr_data,
  input logic              sw_clr_req,
  input logic [7:0]        reg_rd_data,
  input logic              oor_irq
);
  localparam logic [CH_W-1:0] C6 = CH_W'(CH_BASE);
  localparam logic [CH_W-1:0] C7 = CH_W'(CH_BASE + 1);

  logic quiet;
  assign quiet = !reg_wr_en && !sw_clr_req;

  p_const_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_rd_data[3]);

  p_irq_or_r11: assert property (@(posedge clk) disable iff (!rst_n)
    oor_irq == (reg_rd_data[7:4] != 4'h0));

  p_swclr_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clr_req |=> (reg_rd_data[7:4] == 4'h0));

  p_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> ((reg_rd_data[7:4] & $past(reg_rd_data[7:4])) == $past(reg_rd_data[7:4])));

  p_write_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && !sw_clr_req) |=>
      (reg_rd_data[7:4] == ($past(reg_rd_data[7:4]) & $past(reg_wr_data[7:4]))) &&
      (reg_rd_data[2:0] == $past(reg_wr_data[2:0])));

  p_up7_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && res_valid && res_chan == C7 && res_data >= thr_up_c7) |=> reg_rd_data[7]);

  p_up6_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && res_valid && res_chan == C6 && res_data >= thr_up_c6) |=> reg_rd_data[6]);

  p_lo7_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && res_valid && res_chan == C7 && res_data < thr_lo_c7) |=> reg_rd_data[5]);

  p_lo6_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && res_valid && res_chan == C6 && res_data < thr_lo_c6) |=> reg_rd_data[4]);

  p_other_chan_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (quiet && res_valid && res_chan != C6 && res_chan != C7) |=> $stable(reg_rd_data[7:4]));
endmodule

bind window_flag_monitor wcmp_checker #(
  .DATA_W  (DATA_W),
  .CH_W    (CH_W),
  .CH_BASE (CH_BASE)
) u_wcmp_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .res_valid   (res_valid),
  .res_chan    (res_chan),
  .res_data    (res_data),
  .thr_up_c6   (thr_up_c6),
  .thr_lo_c6   (thr_lo_c6),
  .thr_up_c7   (thr_up_c7),
  .thr_lo_c7   (thr_lo_c7),
  .reg_wr_en   (reg_wr_en),
  .reg_wr_data (reg_wr_data),
  .sw_clr_req  (sw_clr_req),
  .reg_rd_data (reg_rd_data),
  .oor_irq     (oor_irq)
);

// File: tb/tb_window_flag_monitor.sv
`timescale 1ns/1ps
module tb_window_flag_monitor;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       res_valid;
  logic [3:0] res_chan;
  logic [7:0] res_data;
  logic [7:0] thr_up_c6, thr_lo_c6, thr_up_c7, thr_lo_c7;
  logic       reg_wr_en;
  logic [7:0] reg_wr_data;
  logic       sw_clr_req;
  logic [7:0] reg_rd_data;
  logic       oor_irq;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  logic [3:0] exp_flags;
  logic [2:0] exp_pr;

  always #2.5 clk = ~clk;

  window_flag_monitor dut (
    .clk(clk), .rst_n(rst_n), .res_valid(res_valid), .res_chan(res_chan),
    .res_data(res_data), .thr_up_c6(thr_up_c6), .thr_lo_c6(thr_lo_c6),
    .thr_up_c7(thr_up_c7), .thr_lo_c7(thr_lo_c7), .reg_wr_en(reg_wr_en),
    .reg_wr_data(reg_wr_data), .sw_clr_req(sw_clr_req),
    .reg_rd_data(reg_rd_data), .oor_irq(oor_irq)
  );

  function automatic logic [3:0] sets(input logic [3:0] ch, input logic [7:0] d);
    sets = {ch == 4'd7 && d >= thr_up_c7, ch == 4'd6 && d >= thr_up_c6,
            ch == 4'd7 && d <  thr_lo_c7, ch == 4'd6 && d <  thr_lo_c6};
  endfunction

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic check_all(input string req);
    check(req, reg_rd_data, {exp_flags, 1'b1, exp_pr});
    check("R11", {7'd0, oor_irq}, {7'd0, |exp_flags});
  endtask

  task automatic idle();
    res_valid = 0; reg_wr_en = 0; sw_clr_req = 0;
  endtask

  // Drive on negedge; the edge in between updates; sample on the next negedge.
  task automatic do_write(input logic [7:0] v, input string req);
    @(negedge clk); idle(); reg_wr_en = 1; reg_wr_data = v;
    exp_flags = exp_flags & v[7:4]; exp_pr = v[2:0];
    @(negedge clk); idle(); check_all(req);
  endtask

  task automatic do_strobe(input logic [3:0] ch, input logic [7:0] d, input string req);
    @(negedge clk); idle(); res_valid = 1; res_chan = ch; res_data = d;
    exp_flags = exp_flags | sets(ch, d);
    @(negedge clk); idle(); check_all(req);
  endtask

  task automatic do_swclr(input string req);
    @(negedge clk); idle(); sw_clr_req = 1; exp_flags = '0;
    @(negedge clk); idle(); check_all(req);
  endtask

  task automatic sweep(input string req);
    for (int ch = 6; ch <= 7; ch++) begin
      for (int d = 0; d < 256; d++) begin
        do_write(8'h07, "R6");
        do_strobe(4'(ch), 8'(d), req);
      end
    end
  endtask

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
    end
  end

  initial begin
    idle(); res_chan = 0; res_data = 0; reg_wr_data = 0;
    thr_up_c6 = 8'h80; thr_lo_c6 = 8'h40; thr_up_c7 = 8'hC0; thr_lo_c7 = 8'h20;
    exp_flags = 4'h0; exp_pr = 3'b111;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", reg_rd_data, 8'h0F);
    check_all("R1");

    // R2 R3 R4: full data sweep under a middle window
    sweep("R3_R4");
    // Thresholds at zero: upper always sets, lower never
    thr_up_c6 = 0; thr_lo_c6 = 0; thr_up_c7 = 0; thr_lo_c7 = 0;
    sweep("R3");
    // Thresholds at full scale: upper only at 255, lower for all below 255
    thr_up_c6 = 8'hFF; thr_lo_c6 = 8'hFF; thr_up_c7 = 8'hFF; thr_lo_c7 = 8'hFF;
    sweep("R4");

    thr_up_c6 = 8'h80; thr_lo_c6 = 8'h40; thr_up_c7 = 8'hC0; thr_lo_c7 = 8'h20;
    // R2 bit positions, one flag at a time
    do_write(8'h00, "R6");
    do_strobe(4'd7, 8'hC0, "R2");
    check("R2", reg_rd_data & 8'hF0, 8'h80);
    do_write(8'h00, "R6");
    do_strobe(4'd6, 8'h80, "R2");
    check("R2", reg_rd_data & 8'hF0, 8'h40);
    do_write(8'h00, "R6");
    do_strobe(4'd7, 8'h1F, "R2");
    check("R2", reg_rd_data & 8'hF0, 8'h20);
    do_write(8'h00, "R6");
    do_strobe(4'd6, 8'h3F, "R2");
    check("R2", reg_rd_data & 8'hF0, 8'h10);

    // R5: sticky, no clear between strobes
    do_write(8'h00, "R6");
    do_strobe(4'd7, 8'hFF, "R5");
    do_strobe(4'd7, 8'h80, "R5");
    do_strobe(4'd6, 8'h00, "R5");
    do_strobe(4'd6, 8'h60, "R5");
    do_strobe(4'd7, 8'h00, "R5");
    do_strobe(4'd6, 8'hFF, "R5");
    check("R5", reg_rd_data & 8'hF0, 8'hF0);

    // R6: partial clears and prescaler storage
    do_write(8'hA5, "R6");
    check("R6", reg_rd_data, 8'hAD);
    do_write(8'h7A, "R6");
    check("R6", reg_rd_data, 8'h2A);
    for (int p = 0; p < 8; p++) do_write(8'(p), "R6");

    // R8: bit 3 written as 0 and as 1
    do_write(8'hF0, "R8");
    check("R8", {7'd0, reg_rd_data[3]}, 8'd1);
    do_write(8'hF8, "R8");
    check("R8", {7'd0, reg_rd_data[3]}, 8'd1);

    // R7: software-reset request, prescaler kept
    do_write(8'hF5, "R6");
    do_strobe(4'd7, 8'hFF, "R3");
    do_strobe(4'd6, 8'h00, "R4");
    do_swclr("R7");
    check("R7", reg_rd_data, 8'h0D);

    // R9: other channels ignored at both data extremes
    for (int ch = 0; ch < 16; ch++) begin
      if (ch != 6 && ch != 7) begin
        do_strobe(4'(ch), 8'h00, "R9");
        do_strobe(4'(ch), 8'hFF, "R9");
      end
    end
    check("R9", reg_rd_data & 8'hF0, 8'h00);

    // R10: write coincides with a strobe that would set flags
    @(negedge clk); idle();
    reg_wr_en = 1; reg_wr_data = 8'hF3; res_valid = 1; res_chan = 4'd7; res_data = 8'hFF;
    exp_flags = exp_flags & 4'hF; exp_pr = 3'd3;
    @(negedge clk); idle(); check_all("R10");
    do_strobe(4'd6, 8'hFF, "R3");
    @(negedge clk); idle();
    reg_wr_en = 1; reg_wr_data = 8'h03; res_valid = 1; res_chan = 4'd6; res_data = 8'h00;
    exp_flags = 4'h0;
    @(negedge clk); idle(); check_all("R10");
    // software-reset request coincides with a strobe
    do_strobe(4'd7, 8'hFF, "R3");
    @(negedge clk); idle();
    sw_clr_req = 1; res_valid = 1; res_chan = 4'd7; res_data = 8'h00;
    exp_flags = 4'h0;
    @(negedge clk); idle(); check_all("R10");
    check("R10", {7'd0, oor_irq}, 8'd0);

    done = 1;
    report();
  end
endmodule